// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a word-wide storage register with four operations chosen by a two-bit mode input. It can keep its contents, move every bit one place toward the most significant end, move every bit one place toward the least significant end, or capture a whole word from a set of shared bidirectional pins. Each shift direction has its own serial input.

The shared pins carry the register contents out and the load data in. They are modelled as three separate signals: an input bus, a drive-value bus and one drive enable. The pins are driven only when two active-low output enables are both low. The block also stops driving them on its own whenever capture mode is selected, so that the incoming word never meets the register's own drivers.

The two end bits also come out on outputs that are always driven, whatever the enables are doing. Several instances can therefore be chained into a longer word by wiring the end bit of one instance into the serial input of the next. An active-low asynchronous reset clears the whole word at once.

Top module: `bidir_shift_reg`

## Requirements
- R1: A low level on `rst_n` clears every register bit to 0 at once, without waiting for a clock edge. While `rst_n` stays low, clock edges and the mode input leave the word at 0.
- R2: With `mode` = 2'b00 at a rising clock edge, the word is unchanged.
- R3: With `mode` = 2'b01 at a rising clock edge, bit n takes the old bit n-1 and bit 0 takes `ser_in_lo`.
- R4: With `mode` = 2'b10 at a rising clock edge, bit n takes the old bit n+1 and the top bit takes `ser_in_hi`.
- R5: With `mode` = 2'b11 at a rising clock edge, the word takes the value on `pin_in`.
- R6: `pin_drive_en` is 1 only when `oe_a_n` and `oe_b_n` are both 0 and `mode` is not 2'b11. Otherwise it is 0.
- R7: `pin_out` always equals the register word, whatever the value of `pin_drive_en`.
- R8: `end_lo` equals bit 0 and `end_hi` equals the top bit at all times, independent of the output enables.
- R9: Hold, shift, capture and reset behave the same way while the pins are released by either output enable.
- R10: When two instances are chained (the low instance's `end_hi` feeds the high instance's `ser_in_lo`, and the high instance's `end_lo` feeds the low instance's `ser_in_hi`), they behave as a single register of twice the width in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes except reset happen on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 keep, 01 shift toward MSB, 10 shift toward LSB, 11 capture from pins |
| ser_in_lo | input | 1 | Serial bit that enters bit 0 on a shift toward the MSB |
| ser_in_hi | input | 1 | Serial bit that enters the top bit on a shift toward the LSB |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| pin_in | input | WIDTH | Value seen on the shared pins |
| pin_out | output | WIDTH | Value the block puts on the shared pins (the register word) |
| pin_drive_en | output | 1 | Shared pins are driven when this is 1 |
| end_lo | output | 1 | Bit 0, always driven |
| end_hi | output | 1 | Top bit, always driven, for chaining |

## Verification
The asynchronous clear and a clocked shift can arrive in the same cycle. The bench provokes this by loading a chained pair, starting a run of shifts, and pulling `rst_n` low in the middle of a clock period while `mode` still asks for a shift. It judges the result at once, before any further edge, by requiring both instances to read zero. It then requires that the next edge, with the shift request still present, leaves them at zero. Capture mode and pin release also coincide by design: the bench samples `pin_drive_en` during the very cycle in which a capture is pending and checks the captured word after that edge.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP    = 2'b00,
    MODE_TO_MSB  = 2'b01,
    MODE_TO_LSB  = 2'b10,
    MODE_CAPTURE = 2'b11
  } usr_mode_e;

  typedef struct packed {
    logic keep;
    logic to_msb;
    logic to_lsb;
    logic capture;
  } usr_ctrl_t;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  usr_mode_e mode,
  output usr_ctrl_t ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (mode)
      MODE_KEEP:    ctrl.keep    = 1'b1;
      MODE_TO_MSB:  ctrl.to_msb  = 1'b1;
      MODE_TO_LSB:  ctrl.to_lsb  = 1'b1;
      MODE_CAPTURE: ctrl.capture = 1'b1;
      default:      ctrl.keep    = 1'b1;
    endcase
  end

  AST_ONE_OPERATION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ctrl.keep, ctrl.to_msb, ctrl.to_lsb, ctrl.capture})); // R2

endmodule

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  usr_ctrl_t        ctrl,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] nxt
);

  localparam int TOP = WIDTH - 1;

  function automatic logic [WIDTH-1:0] step_to_msb(input logic [WIDTH-1:0] w,
                                                   input logic fill);
    logic [WIDTH-1:0] r;
    r[0] = fill;
    for (int i = 1; i < WIDTH; i++) r[i] = w[i-1];
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] step_to_lsb(input logic [WIDTH-1:0] w,
                                                   input logic fill);
    logic [WIDTH-1:0] r;
    r[TOP] = fill;
    for (int i = 0; i < TOP; i++) r[i] = w[i+1];
    return r;
  endfunction

  logic [WIDTH-1:0] up_word;
  logic [WIDTH-1:0] down_word;

  assign up_word   = step_to_msb(cur, ser_in_lo);
  assign down_word = step_to_lsb(cur, ser_in_hi);

  always_comb begin
    nxt = cur;
    if (ctrl.to_msb)       nxt = up_word;
    else if (ctrl.to_lsb)  nxt = down_word;
    else if (ctrl.capture) nxt = pin_in;
  end

endmodule

// File: rtl/usr_pin_ctrl.sv
module usr_pin_ctrl
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oe_a_n,
  input  logic      oe_b_n,
  input  usr_ctrl_t ctrl,
  output logic      drive_en
);

  logic enables_on;
  logic release_for_load;

  assign enables_on       = ~oe_a_n & ~oe_b_n;
  assign release_for_load = ctrl.capture;
  assign drive_en         = enables_on & ~release_for_load;

  AST_RELEASE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.capture |-> !drive_en); // R6
  AST_RELEASE_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !drive_en); // R6

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic             pin_drive_en,
  output logic             end_lo,
  output logic             end_hi
);

  localparam int TOP = WIDTH - 1;

  usr_ctrl_t        ctrl;
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_d;

  usr_mode_decode u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (usr_mode_e'(mode)),
    .ctrl  (ctrl)
  );

  usr_next_state #(.WIDTH(WIDTH)) u_next (
    .cur       (word_q),
    .ctrl      (ctrl),
    .ser_in_lo (ser_in_lo),
    .ser_in_hi (ser_in_hi),
    .pin_in    (pin_in),
    .nxt       (word_d)
  );

  usr_pin_ctrl u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .ctrl     (ctrl),
    .drive_en (pin_drive_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign pin_out = word_q;
  assign end_lo  = word_q[0];
  assign end_hi  = word_q[TOP];

  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> $stable(pin_out)); // R2
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (pin_out[0] == $past(ser_in_lo)) &&
                        (pin_out[TOP:1] == $past(pin_out[TOP-1:0]))); // R3
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (pin_out[TOP] == $past(ser_in_hi)) &&
                        (pin_out[TOP-1:0] == $past(pin_out[TOP:1]))); // R4
  AST_CAPTURE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (pin_out == $past(pin_in))); // R5

endmodule

// File: tb/tb_bidir_shift_reg.sv
module tb_bidir_shift_reg;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ser_lo = 1'b0, ser_hi = 1'b0;
  logic oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [W-1:0] pin_lo = '0, pin_hi = '0;
  logic [W-1:0] out_lo, out_hi;
  logic en_lo, en_hi;
  logic lo_end_lo, lo_end_hi, hi_end_lo, hi_end_hi;

  int checks = 0;
  int errors = 0;
  logic [2*W-1:0] model = '0;

  typedef struct {
    logic [2*W-1:0] word;
    string          tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // low half of the 16-bit chain
  bidir_shift_reg #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ser_in_lo(ser_lo), .ser_in_hi(hi_end_lo),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_lo),
    .pin_out(out_lo), .pin_drive_en(en_lo),
    .end_lo(lo_end_lo), .end_hi(lo_end_hi));

  // high half of the 16-bit chain
  bidir_shift_reg #(.WIDTH(W)) dut_hi (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ser_in_lo(lo_end_hi), .ser_in_hi(ser_hi),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .pin_in(pin_hi),
    .pin_out(out_hi), .pin_drive_en(en_hi),
    .end_lo(hi_end_lo), .end_hi(hi_end_hi));

  task automatic chk(input string req, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_drive(input string req, input logic exp);
    chk(req, {14'd0, en_hi, en_lo}, {14'd0, exp, exp});
  endtask

  // monitor: compare queued expectations a quarter period after each edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, {out_hi, out_lo}, e.word);
      chk({e.tag, " R8"}, {12'd0, hi_end_hi, hi_end_lo, lo_end_hi, lo_end_lo},
          {12'd0, e.word[15], e.word[8], e.word[7], e.word[0]});
    end
  end

  // driver: apply one cycle's inputs at the falling edge, push the expected word
  task automatic step(input logic [1:0] m, input logic sl, input logic sh,
                      input logic [2*W-1:0] pins, input string tag);
    @(negedge clk);
    mode = m; ser_lo = sl; ser_hi = sh;
    {pin_hi, pin_lo} = pins;
    #1;
    chk_drive("R6", (!oe_a_n && !oe_b_n && m != 2'b11));
    unique case (m)
      2'b00: model = model;
      2'b01: model = {model[2*W-2:0], sl};
      2'b10: model = {sh, model[2*W-1:1]};
      default: model = pins;
    endcase
    @(posedge clk);
    sb.push_back('{word: model, tag: tag});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    chk("R1 reset state", {out_hi, out_lo}, '0);
    chk_drive("R6 reset state", 1'b1);
    @(negedge clk); rst_n = 1'b1;

    step(2'b11, 0, 0, 16'hA5C3, "R5 capture");
    step(2'b00, 1, 1, 16'hFFFF, "R2 keep");
    step(2'b00, 0, 1, 16'h0000, "R2 keep");

    for (int i = 0; i < 16; i++) step(2'b01, i[0] ^ i[2], 0, '0, "R3 R10 chain up");
    for (int i = 0; i < 16; i++) step(2'b10, 0, i[1], '0, "R4 R10 chain down");

    oe_a_n = 1'b1;
    step(2'b00, 0, 0, '0, "R9 keep released");
    step(2'b11, 0, 0, 16'h3C69, "R9 R7 capture released");
    step(2'b01, 1, 0, '0, "R9 R7 shift released");
    oe_a_n = 1'b0; oe_b_n = 1'b1;
    step(2'b10, 0, 1, '0, "R9 R7 shift released b");
    oe_b_n = 1'b0;
    step(2'b00, 0, 0, '0, "R2 R7 keep driven");

    step(2'b11, 0, 0, 16'hFFFF, "R5 capture ones");
    step(2'b01, 0, 0, '0, "R3 before reset");
    step(2'b01, 0, 0, '0, "R3 before reset");
    @(negedge clk);
    #2; rst_n = 1'b0;
    #1;
    chk("R1 async clear mid-shift", {out_hi, out_lo}, '0);
    @(posedge clk); #(CLK_PERIOD/4);
    chk("R1 held under shift request", {out_hi, out_lo}, '0);
    model = '0;
    @(negedge clk); rst_n = 1'b1;
    step(2'b10, 0, 1, '0, "R4 after reset");
    @(negedge clk);
    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule